// File: doc/BRIEF.md
# Channel-Select Sampling Sequencer

This block is the control side of a ten-channel sampling converter. The host writes one 16-bit command word that carries a per-channel enable mask, the index of the channel to sample, a settling-delay request and a go bit. When the request is legal and the sequencer is idle, it pulses a start strobe to the converter with the channel index beside it. It then waits for the converter's completion strobe. Channels 0 to 7 are external inputs. Channel 8 is a +10 V reference and channel 9 is a 0 V reference.

When the converter returns a sample, the sequencer stores it in a result register. The raw sample is offset binary, and the sequencer inverts the top bit on the way in so the host reads two's complement. It also sets a completion flag in a status register. The host clears that flag by writing a one to it. An enable register gates the flag onto a level interrupt line. All host reads go through one registered read port.

Top module: `adcseq_top`

## Requirements
- R1: The command word has four fields. Bit 0 is go, bits 4:1 are the channel index, bits 14:5 are the enable mask (bit 5+n enables channel n), and bit 15 is the settle flag. A command with go set and no settle flag, written while idle to a legal enabled channel, makes `cnv_start` high for exactly one cycle, in the cycle after the write edge, with `cnv_chan` equal to the index.
- R2: With the settle flag set, the start strobe comes exactly DELAY_CYCLES (default 64) cycles later than it would without the flag.
- R3: A go command is dropped when its index is 10 or above, or when the mask bit for its channel is clear. No start strobe follows, and the status done bit stays clear.
- R4: A go command that arrives while the sequencer is settling or converting is ignored. Only the conversion already running completes.
- R5: On the edge where the converter's `cnv_done` is sampled during a conversion, the result register takes `cnv_data` with bit 15 inverted, and status bit 2 (value 0x4) becomes 1.
- R6: Writing the status register (address 1) with bit 2 set clears done. Writing it with bit 2 clear leaves done unchanged. A completion in the same cycle as the clear wins.
- R7: `irq` is high exactly when status bit 2 and bit 2 of the enable register (address 2) are both 1.
- R8: Registers are read at `rd_addr`: 0 for the command, 1 for status, 2 for the enable register, 3 for the result. `rdata` shows the register addressed at the previous edge. A read of the command register returns the last word written.
- R9: After reset, status, the enable register, the result and the command register are all zero, and `irq` and `cnv_start` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write register address |
| wdata | input | 16 | Host write data |
| rd_addr | input | 2 | Host read register address |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Completion interrupt, level |
| cnv_start | output | 1 | One-cycle start strobe to the converter |
| cnv_chan | output | 4 | Channel index presented with the start strobe |
| cnv_done | input | 1 | Converter completion strobe |
| cnv_data | input | 16 | Converter sample, offset binary |

## Verification
The start strobe is due in the cycle after the command write edge, or DELAY_CYCLES cycles after that when the settle flag is set. The done bit, the interrupt and the result register all change on the edge that samples `cnv_done`. Read data appears one cycle after the read address. The driver task records the exact cycle in which each accepted command's strobe must appear and queues it. The monitor compares channel and cycle at the falling edge, so any extra or missing strobe counts as a failure. Register contents are read back only after the converter stub has finished its fixed latency.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int CMD_W     = 16;
  localparam int IDX_W     = 4;
  localparam int CH_NUM    = 10;
  localparam int GO_BIT    = 0;
  localparam int IDX_LSB   = 1;
  localparam int MASK_LSB  = 5;
  localparam int SETTLE_BIT = 15;
  localparam int DONE_BIT  = 2;

  localparam logic [1:0] ADR_CMD  = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_IEN  = 2'd2;
  localparam logic [1:0] ADR_DATA = 2'd3;

  typedef struct packed {
    logic              settle;
    logic [CH_NUM-1:0] mask;
    logic [IDX_W-1:0]  idx;
    logic              go;
  } cmd_t;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_CONV   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adcseq_decode.sv
module adcseq_decode
  import adcseq_pkg::*;
(
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             req,
  output logic             req_settle,
  output logic [IDX_W-1:0] req_idx
);
  cmd_t              fields;
  logic [CH_NUM-1:0] hit;

  assign fields = cmd_t'(cmd_word);

  // one comparator per channel: selected index and its enable bit
  for (genvar g = 0; g < CH_NUM; g++) begin : g_hit
    assign hit[g] = (fields.idx == IDX_W'(g)) & fields.mask[g];
  end

  assign req        = cmd_wr & fields.go & (|hit);
  assign req_settle = fields.settle;
  assign req_idx    = fields.idx;
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int DELAY_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_settle,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             cnv_done,
  output logic             cnv_start,
  output logic [IDX_W-1:0] cnv_chan,
  output logic             conv_active,
  output logic             sample_take
);
  localparam int CNT_W = $clog2(DELAY_CYCLES + 1);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic             start_q;
  logic [IDX_W-1:0] chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SEQ_IDLE;
      cnt     <= '0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      start_q <= 1'b0;
      case (state)
        SEQ_IDLE: begin
          if (req) begin
            chan_q <= req_idx;
            if (req_settle) begin
              state <= SEQ_SETTLE;
              cnt   <= CNT_W'(DELAY_CYCLES - 1);
            end else begin
              start_q <= 1'b1;
              state   <= SEQ_CONV;
            end
          end
        end
        SEQ_SETTLE: begin
          if (cnt == '0) begin
            start_q <= 1'b1;
            state   <= SEQ_CONV;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        SEQ_CONV: begin
          if (cnv_done) state <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign cnv_start   = start_q;
  assign cnv_chan    = chan_q;
  assign conv_active = (state == SEQ_CONV);
  assign sample_take = (state == SEQ_CONV) & cnv_done;
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
  import adcseq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic [1:0]        rd_addr,
  input  logic              sample_take,
  input  logic [DATA_W-1:0] cnv_data,
  output logic [CMD_W-1:0]  rdata,
  output logic              irq,
  output logic              done_flag,
  output logic              ie_flag
);
  localparam logic [DATA_W-1:0] SIGN_FLIP = {1'b1, {(DATA_W-1){1'b0}}};

  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_n;
  logic              ie_q, ie_n;
  logic              irq_q;
  logic [CMD_W-1:0]  rd_q;
  logic              clr_hit;

  assign clr_hit = wr_en & (wr_addr == ADR_STAT) & wdata[DONE_BIT];

  always_comb begin
    done_n = done_q;
    if (clr_hit)     done_n = 1'b0;
    if (sample_take) done_n = 1'b1;
    ie_n = ie_q;
    if (wr_en && wr_addr == ADR_IEN) ie_n = wdata[DONE_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
      done_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == ADR_CMD) cmd_q <= wdata;
      if (sample_take) data_q <= cnv_data ^ SIGN_FLIP;
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= done_n & ie_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (rd_addr)
        ADR_CMD:  rd_q <= cmd_q;
        ADR_STAT: rd_q <= CMD_W'(done_q) << DONE_BIT;
        ADR_IEN:  rd_q <= CMD_W'(ie_q) << DONE_BIT;
        default:  rd_q <= CMD_W'(data_q);
      endcase
    end
  end

  assign rdata     = rd_q;
  assign irq       = irq_q;
  assign done_flag = done_q;
  assign ie_flag   = ie_q;
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int DATA_W       = 16,
  parameter int DELAY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [15:0]       wdata,
  input  logic [1:0]        rd_addr,
  output logic [15:0]       rdata,
  output logic              irq,
  output logic              cnv_start,
  output logic [3:0]        cnv_chan,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data
);
  logic             cmd_wr;
  logic             req, req_settle;
  logic [IDX_W-1:0] req_idx;
  logic             conv_active, sample_take;
  logic             done_flag, ie_flag;

  assign cmd_wr = wr_en & (wr_addr == ADR_CMD);

  adcseq_decode u_dec (
    .cmd_wr     (cmd_wr),
    .cmd_word   (wdata),
    .req        (req),
    .req_settle (req_settle),
    .req_idx    (req_idx)
  );

  adcseq_ctrl #(.DELAY_CYCLES(DELAY_CYCLES)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req         (req),
    .req_settle  (req_settle),
    .req_idx     (req_idx),
    .cnv_done    (cnv_done),
    .cnv_start   (cnv_start),
    .cnv_chan    (cnv_chan),
    .conv_active (conv_active),
    .sample_take (sample_take)
  );

  adcseq_regs #(.DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wdata       (wdata),
    .rd_addr     (rd_addr),
    .sample_take (sample_take),
    .cnv_data    (cnv_data),
    .rdata       (rdata),
    .irq         (irq),
    .done_flag   (done_flag),
    .ie_flag     (ie_flag)
  );
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk
  import adcseq_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic [15:0] wdata,
  input logic        cnv_start,
  input logic [3:0]  cnv_chan,
  input logic        cnv_done,
  input logic        irq,
  input logic        done_flag,
  input logic        ie_flag,
  input logic        conv_active
);
  // R1
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cnv_start |=> !cnv_start);

  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnv_start |-> (cnv_chan < IDX_W'(CH_NUM)));

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    cnv_start |-> !$past(conv_active));

  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (rst)
    (cnv_done && conv_active) |=> done_flag);

  // R6
  w1c_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADR_STAT && wdata[DONE_BIT] && !(cnv_done && conv_active))
      |=> !done_flag);

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done_flag && ie_flag));
endmodule

bind adcseq_top adcseq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wdata       (wdata),
  .cnv_start   (cnv_start),
  .cnv_chan    (cnv_chan),
  .cnv_done    (cnv_done),
  .irq         (irq),
  .done_flag   (done_flag),
  .ie_flag     (ie_flag),
  .conv_active (conv_active)
);

// File: tb/sim_adcseq_top.sv
`timescale 1ns/1ps
module sim_adcseq_top;
  localparam int DELAY = 64;
  localparam int LAT   = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wdata = 16'h0;
  logic [1:0]  rd_addr = 2'd0;
  logic [15:0] rdata;
  logic        irq;
  logic        cnv_start;
  logic [3:0]  cnv_chan;
  logic        cnv_done = 1'b0;
  logic [15:0] cnv_data = 16'h0;

  int checks = 0;
  int failures = 0;
  longint cyc = 0;
  logic [15:0] stub_val = 16'h0;
  int exp_chan_q[$];
  longint exp_cyc_q[$];
  bit done_run = 0;

  adcseq_top #(.DATA_W(16), .DELAY_CYCLES(DELAY)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wdata(wdata),
    .rd_addr(rd_addr), .rdata(rdata), .irq(irq), .cnv_start(cnv_start),
    .cnv_chan(cnv_chan), .cnv_done(cnv_done), .cnv_data(cnv_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cmd(input bit go, input int idx, input logic [9:0] mask, input bit settle);
    return {settle, mask, 4'(idx), go};
  endfunction

  // driver: one write; queues the expected start when the command is legal and idle
  task automatic write_reg(input logic [1:0] a, input logic [15:0] d, input bit expect_start);
    @(negedge clk);
    if (expect_start) begin
      exp_chan_q.push_back(int'(d[4:1]));
      exp_cyc_q.push_back(cyc + 1 + (d[15] ? DELAY : 0));
    end
    wr_en = 1'b1; wr_addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: every start strobe must match the head of the queue (R1, R2, R3, R4)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cnv_start) begin
        if (exp_chan_q.size() == 0) begin
          check(1'b0, "R3/R4 unexpected start", longint'(cnv_chan), 0);
        end else begin
          int ec;
          longint et;
          ec = exp_chan_q.pop_front();
          et = exp_cyc_q.pop_front();
          check(int'(cnv_chan) == ec, "R1 start channel", longint'(cnv_chan), ec);
          check(cyc == et, "R1/R2 start cycle", cyc, et);
        end
      end
    end
  end

  // behavioural converter: fixed latency, returns stub_val
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && cnv_start) begin
        repeat (LAT - 1) @(negedge clk);
        cnv_done = 1'b1;
        cnv_data = stub_val;
        @(negedge clk);
        cnv_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    logic [15:0] v;
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R9 reset state
    check(irq == 1'b0, "R9 irq", irq, 0);
    check(cnv_start == 1'b0, "R9 cnv_start", cnv_start, 0);
    read_reg(2'd1, v); check(v == 16'h0, "R9 status", v, 0);
    read_reg(2'd2, v); check(v == 16'h0, "R9 enable", v, 0);
    read_reg(2'd3, v); check(v == 16'h0, "R9 result", v, 0);
    read_reg(2'd0, v); check(v == 16'h0, "R9 command", v, 0);

    // enable interrupt
    write_reg(2'd2, 16'h0004, 0);
    read_reg(2'd2, v); check(v == 16'h0004, "R8 enable readback", v, 16'h0004);

    // R1/R5/R7: channel 3, no delay
    stub_val = 16'h0000;
    write_reg(2'd0, mk_cmd(1, 3, 10'b00_0000_1000, 0), 1);
    idle(LAT + 4);
    read_reg(2'd1, v); check(v == 16'h0004, "R5 done set", v, 16'h0004);
    check(irq == 1'b1, "R7 irq with enable", irq, 1);
    read_reg(2'd3, v); check(v == 16'h8000, "R5 result sign flip", v, 16'h8000);
    read_reg(2'd0, v); check(v == mk_cmd(1, 3, 10'b00_0000_1000, 0), "R8 command readback", v, mk_cmd(1, 3, 10'b00_0000_1000, 0));

    // R6: write 0 keeps done, write 0x4 clears
    write_reg(2'd1, 16'h0000, 0);
    read_reg(2'd1, v); check(v == 16'h0004, "R6 zero write keeps done", v, 16'h0004);
    write_reg(2'd1, 16'h0004, 0);
    read_reg(2'd1, v); check(v == 16'h0000, "R6 w1c clears", v, 0);
    check(irq == 1'b0, "R7 irq drops", irq, 0);

    // R2: channel 9 with settle delay
    stub_val = 16'hFFFF;
    write_reg(2'd0, mk_cmd(1, 9, 10'b10_0000_0000, 1), 1);
    idle(DELAY + LAT + 4);
    read_reg(2'd3, v); check(v == 16'h7FFF, "R2/R5 delayed result", v, 16'h7FFF);
    write_reg(2'd1, 16'h0004, 0);

    // R3: channel with mask bit clear, and index out of range
    write_reg(2'd0, mk_cmd(1, 5, 10'b11_1101_1111, 0), 0);
    idle(DELAY + LAT + 4);
    read_reg(2'd1, v); check(v == 16'h0000, "R3 disabled channel no done", v, 0);
    write_reg(2'd0, mk_cmd(1, 12, 10'b11_1111_1111, 0), 0);
    idle(LAT + 4);
    read_reg(2'd1, v); check(v == 16'h0000, "R3 index out of range no done", v, 0);
    write_reg(2'd0, mk_cmd(0, 2, 10'b00_0000_0100, 0), 0);
    idle(LAT + 4);
    read_reg(2'd1, v); check(v == 16'h0000, "R1 go clear no done", v, 0);

    // R4: second command while converting is ignored
    stub_val = 16'h8123;
    write_reg(2'd0, mk_cmd(1, 1, 10'b00_0000_0010, 0), 1);
    write_reg(2'd0, mk_cmd(1, 2, 10'b00_0000_0100, 0), 0);
    idle(LAT + 4);
    read_reg(2'd3, v); check(v == 16'h0123, "R4 first conversion result", v, 16'h0123);
    write_reg(2'd1, 16'h0004, 0);
    // ignored while settling as well
    write_reg(2'd0, mk_cmd(1, 8, 10'b01_0000_0000, 1), 1);
    write_reg(2'd0, mk_cmd(1, 0, 10'b00_0000_0001, 0), 0);
    idle(DELAY + LAT + 4);
    write_reg(2'd1, 16'h0004, 0);

    // R7: enable off, done set, irq stays low
    write_reg(2'd2, 16'h0000, 0);
    stub_val = 16'h1234;
    write_reg(2'd0, mk_cmd(1, 0, 10'b00_0000_0001, 0), 1);
    idle(LAT + 4);
    read_reg(2'd1, v); check(v == 16'h0004, "R5 done without enable", v, 16'h0004);
    check(irq == 1'b0, "R7 irq gated off", irq, 0);
    read_reg(2'd3, v); check(v == 16'h9234, "R5 result channel 0", v, 16'h9234);
    write_reg(2'd2, 16'h0004, 0);
    idle(1);
    check(irq == 1'b1, "R7 irq after enabling", irq, 1);

    check(exp_chan_q.size() == 0, "R1/R4 all starts seen", exp_chan_q.size(), 0);
    done_run = 1;
    report();
  end
endmodule